// File: doc/BRIEF.md
# SMBus Block-Transfer Register Slave

This block is an SMBus target that exposes a small internal register file over two wires. It accepts exactly two transfer types: a block write (address with write bit, register pointer, byte count, then that many data bytes) and a block read (address with write bit, register pointer, repeated start, address with read bit, after which the target returns a byte count and the data). SCL and SDA are brought into the system clock domain through two flip-flops. Start and stop are recognised as SDA edges while SCL is high. The target drives SDA only by pulling it low, through `sda_oe_o`, and it never stretches the clock.

Incoming write bytes go into a staging buffer. The register file is updated only when a stop closes a block write that delivered exactly the announced number of bytes. Any other sequence leaves the registers as they were: a wrong address, the general call address, a bad pointer or count, a short or over-long data phase, a restart, or a timeout. A counter measures how long SCL stays low during a transfer. When the count reaches `TOUT_CYC` system clocks, the target releases SDA, drops the transfer and waits for a new start. The bus carries no data stream that could back up, so the block has no valid/ready interface. The register contents are visible as a flat status vector.

Top module: `smb_blkreg_slave`

## Requirements
- R1: An address byte whose upper 7 bits equal `addr_strap` is acknowledged, provided the strap is nonzero. Any other address gets no acknowledge, and the target ignores the bus until the next start or stop.
- R2: The general call address 7'b0000000 is never acknowledged.
- R3: When a block write with pointer P and count N ends in a stop after exactly N acknowledged data bytes, registers P to P+N-1 take those bytes in order. Registers change at no other time.
- R4: If the stop comes before N data bytes have been received, no register changes.
- R5: A data byte beyond the count N is not acknowledged, and that write commits nothing.
- R6: The pointer byte is acknowledged only if it is below `NREG`. The count byte is acknowledged only if it lies between 1 and `NREG`-P. Otherwise the byte is NACKed and nothing is committed.
- R7: In a block read from pointer P, the first byte sent is the count `NREG`-P. The registers follow from P upward. A master NACK ends the sending.
- R8: An address byte with the read bit that is not preceded by an acknowledged pointer byte in the same transfer is not acknowledged.
- R9: After SCL has been low for `TOUT_CYC` system clocks during a transfer, the target releases SDA and abandons the transfer, committing nothing.
- R10: After a timeout, the next start is accepted at once, without any stop first.
- R11: A start seen in any state restarts address reception, and a block write cut off by a repeated start commits nothing.
- R12: After reset all registers are zero and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| addr_strap | input | 7 | Hardware-selected 7-bit target address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NREG*8 | Register file contents; register i is bits [8i+7:8i] |

## Verification
The bench mixes random legal writes and reads with damaged writes (one byte short, one byte extra, foreign address, count past the end of the file) and checks every acknowledge bit and the full register file after each transfer. A design that committed on each acknowledged byte would show partial updates after short writes. One that ignored the count would accept and commit the extra byte. One that checked only address equality would acknowledge the general call. Directed cases include a write cut off by a repeated start, a read attempted with no pointer phase, and a clock held low while the target is pulling SDA. A design with no timeout keeps SDA low for ever, and one that needs a stop after the timeout misses the next start.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_CMD,
    S_CMD_ACK,
    S_CNT,
    S_CNT_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RBYTE,
    S_RACK,
    S_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sr[SYNC_STAGES-1];
      sda_q  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sr[SYNC_STAGES-1];
  assign sda_o      = sda_sr[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_scl_watch.sv
module smb_scl_watch #(
  parameter int TOUT_CYC = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic scl_i,
  output logic tout_o
);
  localparam int CW = $clog2(TOUT_CYC + 1);
  logic [CW-1:0] cnt;

  assign tout_o = armed_i && !scl_i && (cnt == CW'(TOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!armed_i || scl_i || tout_o) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  // R9: the low-time counter never runs past the limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TOUT_CYC));
endmodule

// File: rtl/smb_blkreg_slave.sv
module smb_blkreg_slave
  import smb_blk_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int TOUT_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        addr_strap,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int PW = $clog2(NREG + 1);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tout;
  smb_state_e state;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, tx;
  logic          sda_oe_q, have_cmd, is_rd, mnack;
  logic [PW-1:0] ptr, cnt, rcv;
  logic [7:0]    stage [NREG];
  logic [7:0]    regs  [NREG];
  logic [NREG-1:0] wmask;
  logic [7:0]    rd_byte, rd_cnt;
  logic          commit;

  smb_line_cond #(.SYNC_STAGES(2)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_scl_watch #(.TOUT_CYC(TOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .armed_i(state != S_IDLE), .scl_i(scl_s), .tout_o(tout)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++)
      wmask[i] = (32'(i) >= 32'(ptr)) && (32'(i) < 32'(ptr) + 32'(cnt));
  end

  assign rd_byte = (ptr < PW'(NREG)) ? regs[ptr[IW-1:0]] : 8'hFF;
  assign rd_cnt  = 8'(NREG) - 8'(ptr);
  assign commit  = stop_det && (state == S_WDAT) && (bitcnt == 4'd1) &&
                   (cnt != '0) && (rcv == cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < NREG; i++) if (wmask[i]) regs[i] <= stage[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; sh <= '0; tx <= '0;
      sda_oe_q <= 1'b0; have_cmd <= 1'b0; is_rd <= 1'b0; mnack <= 1'b0;
      ptr <= '0; cnt <= '0; rcv <= '0;
      for (int i = 0; i < NREG; i++) stage[i] <= 8'h00;
    end else if (tout) begin
      state <= S_IDLE; sda_oe_q <= 1'b0; have_cmd <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR; bitcnt <= '0; sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; sda_oe_q <= 1'b0; have_cmd <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR, S_CMD, S_CNT, S_WDAT: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            state <= S_IGNORE;
            if (state == S_ADDR) begin
              if (sh[7:1] == addr_strap && addr_strap != 7'd0 && (!sh[0] || have_cmd)) begin
                sda_oe_q <= 1'b1; state <= S_ADDR_ACK; is_rd <= sh[0];
                if (!sh[0]) have_cmd <= 1'b0;
              end
            end else if (state == S_CMD) begin
              if (32'(sh) < 32'(NREG)) begin
                sda_oe_q <= 1'b1; state <= S_CMD_ACK;
                ptr <= sh[PW-1:0]; have_cmd <= 1'b1;
              end
            end else if (state == S_CNT) begin
              if (sh != 8'd0 && 32'(sh) <= 32'(NREG) - 32'(ptr)) begin
                sda_oe_q <= 1'b1; state <= S_CNT_ACK;
                cnt <= sh[PW-1:0]; rcv <= '0;
              end
            end else begin
              if (rcv < cnt) begin
                stage[IW'(ptr + rcv)] <= sh;
                rcv <= rcv + 1'b1;
                sda_oe_q <= 1'b1; state <= S_WDAT_ACK;
              end
            end
          end
        end
        S_ADDR_ACK, S_CMD_ACK, S_CNT_ACK, S_WDAT_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0; bitcnt <= '0;
            case (state)
              S_ADDR_ACK: begin
                if (is_rd) begin
                  tx <= rd_cnt; sda_oe_q <= ~rd_cnt[7]; state <= S_RBYTE;
                end else state <= S_CMD;
              end
              S_CMD_ACK: state <= S_CNT;
              default:   state <= S_WDAT;
            endcase
          end
        end
        S_RBYTE: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_q <= 1'b0; bitcnt <= '0; state <= S_RACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe_q <= ~tx[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mnack <= sda_s;
          else if (scl_fall) begin
            if (mnack) state <= S_IGNORE;
            else begin
              tx <= rd_byte; sda_oe_q <= ~rd_byte[7];
              ptr <= ptr + 1'b1; state <= S_RBYTE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs[g];
  end

  // R1: SDA is taken low only just after a synchronised SCL fall
  p_drive_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> $past(scl_fall));
  // R2: an address acknowledge never happens with a zero strap
  p_gc_noack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_q) && state == S_ADDR_ACK) |-> addr_strap != 7'd0);
  // R3: the register file changes only right after a stop
  p_regs_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(stop_det));
  // R9: a timeout leaves SDA released
  p_tout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tout |=> !sda_oe_q);
endmodule

// File: tb/test_smb_blkreg_slave.sv
module test_smb_blkreg_slave;
  localparam int NREG = 8;
  localparam int TOUT = 300;
  localparam int Q    = 5;
  localparam logic [6:0] STRAP = 7'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] mreg [NREG];
  logic [7:0] wbuf [NREG+2];

  always #10 clk = ~clk;

  smb_blkreg_slave #(.NREG(NREG), .TOUT_CYC(TOUT)) i_smb_blkreg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap(STRAP), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = (sda_bus == 1'b0);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; scl_m = 1'b0;
    end
    wq(Q); sda_m = nack; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] === mreg[i], req, regs[i*8 +: 8], mreg[i]);
  endtask

  // Block write with nsend data bytes; model committed only on a full valid write
  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] n,
                          input int nsend, input string req);
    bit ack, ok;
    start_c();
    send_byte({a, 1'b0}, ack);
    chk(ack == (a == STRAP && a != 7'd0), req, ack, (a == STRAP));
    ok = ack;
    if (ok) begin
      send_byte(cmd, ack);
      chk(ack == (cmd < NREG), "R6 pointer ack", ack, (cmd < NREG));
      ok = ack;
    end
    if (ok) begin
      send_byte(n, ack);
      chk(ack == (n >= 1 && 32'(n) <= NREG - 32'(cmd)), "R6 count ack", ack, 0);
      ok = ack;
    end
    if (ok) begin
      for (int j = 0; j < nsend; j++) begin
        send_byte(wbuf[j], ack);
        chk(ack == (j < 32'(n)), (j < 32'(n)) ? "R3 data ack" : "R5 extra byte nack", ack, (j < 32'(n)));
        if (!ack) begin ok = 1'b0; break; end
      end
    end
    stop_c();
    wq(4);
    if (ok && nsend == 32'(n))
      for (int j = 0; j < 32'(n); j++) mreg[32'(cmd) + j] = wbuf[j];
    check_regs(req);
  endtask

  task automatic do_read(input logic [7:0] cmd);
    bit ack;
    logic [7:0] b;
    int cnt;
    start_c();
    send_byte({STRAP, 1'b0}, ack);
    send_byte(cmd, ack);
    start_c();
    send_byte({STRAP, 1'b1}, ack);
    chk(ack, "R7 read address ack", ack, 1);
    recv_byte(1'b0, b);
    cnt = NREG - 32'(cmd);
    chk(32'(b) == cnt, "R7 count byte", b, cnt);
    for (int j = 0; j < cnt; j++) begin
      recv_byte(j == cnt - 1, b);
      chk(b === mreg[32'(cmd) + j], "R7 read data", b, mreg[32'(cmd) + j]);
    end
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    stop_c();
    wq(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] cmd, n;
    int kind;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(5);

    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    check_regs("R12 regs zero");

    // R3 basic write then R7 read back
    for (int j = 0; j < NREG + 2; j++) wbuf[j] = 8'(8'h11 * (j + 1));
    do_write(STRAP, 8'd2, 8'd4, 4, "R3 full write");
    do_read(8'd2);
    do_read(8'd0);

    // R2 general call, R1 foreign address
    do_write(7'h00, 8'd0, 8'd1, 1, "R2 general call");
    do_write(STRAP ^ 7'h01, 8'd0, 8'd1, 1, "R1 foreign address");

    // R4 short write, R5 extra byte, R6 bad pointer / count
    do_write(STRAP, 8'd0, 8'd3, 2, "R4 short write");
    do_write(STRAP, 8'd1, 8'd2, 3, "R5 extra byte");
    do_write(STRAP, 8'd8, 8'd1, 1, "R6 pointer out of range");
    do_write(STRAP, 8'd6, 8'd3, 3, "R6 count past end");
    do_write(STRAP, 8'd0, 8'd0, 0, "R6 zero count");
    do_write(STRAP, 8'd0, 8'd8, 8, "R3 whole file");

    // R8 read without pointer phase
    start_c(); send_byte({STRAP, 1'b1}, ack); stop_c(); wq(4);
    chk(!ack, "R8 read without pointer", ack, 0);

    // R11 write cut by repeated start; only the second write lands
    wbuf[0] = 8'hC3;
    start_c(); send_byte({STRAP, 1'b0}, ack); send_byte(8'd4, ack);
    send_byte(8'd3, ack); send_byte(8'h5A, ack);
    start_c(); send_byte({STRAP, 1'b0}, ack); send_byte(8'd7, ack);
    send_byte(8'd1, ack); send_byte(8'hC3, ack); stop_c(); wq(4);
    mreg[7] = 8'hC3;
    check_regs("R11 repeated start");

    // R9 timeout while the target pulls SDA low, R10 new start afterwards
    start_c(); send_byte({STRAP, 1'b0}, ack); send_byte(8'd0, ack);
    send_byte(8'd2, ack); send_byte(8'hEE, ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'(8'h77 >> i); wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    chk(sda_oe == 1'b1, "R1 ack drive before timeout", sda_oe, 1);
    wq(TOUT + 20);
    chk(sda_oe == 1'b0, "R9 released after timeout", sda_oe, 0);
    check_regs("R9 no commit on timeout");
    for (int j = 0; j < 2; j++) wbuf[j] = 8'(8'h9A + j);
    do_write(STRAP, 8'd3, 8'd2, 2, "R10 start after timeout");

    // Random mix
    for (int it = 0; it < 30; it++) begin
      kind = $urandom_range(0, 5);
      for (int j = 0; j < NREG + 2; j++) wbuf[j] = 8'($urandom);
      cmd = 8'($urandom_range(0, NREG - 2));
      n   = 8'($urandom_range(2, NREG - 32'(cmd)));
      case (kind)
        0, 1: do_write(STRAP, cmd, n, 32'(n), "R3 random write");
        2:    do_write(STRAP, cmd, n, 32'(n) - 1, "R4 random short");
        3:    do_write(STRAP, cmd, n, 32'(n) + 1, "R5 random extra");
        4:    do_write(STRAP ^ 7'(1 << $urandom_range(0, 6)), cmd, n, 32'(n), "R1 random foreign");
        default: do_read(cmd);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule